// File: doc/BRIEF.md
# Frame-Indexed Page Lookup Engine

This block translates virtual addresses through a table that holds one entry for each physical frame. Each entry says which virtual page currently lives in that frame, and carries a valid flag. A lookup searches the table for the requested page. The position of the matching entry is the frame number, so the table stores no frame field at all.

A requester presents a virtual address while the engine reports it is ready. The engine then checks one table entry per clock, starting at index zero. It stops at the first valid entry that holds the requested page. It then returns the physical address, made of the frame index with the untouched byte offset below it. If it reaches the end of the table without a match, it reports a page fault. The result is marked by a one-cycle completion pulse.

A separate write port installs or removes a mapping, but only while the engine is idle. A write that arrives during a search is dropped. Hashing and replacement choices are made elsewhere.

Top module: `frame_lookup_engine`

## Requirements
- R1: After reset, `req_ready` is 1 and `done`, `hit` and `fault` are 0, and every table entry is invalid.
- R2: A request is taken only when `req_valid` and `req_ready` are both 1. From the next cycle until completion, `req_ready` stays 0, and further requests are not taken.
- R3: On a hit, `done` and `hit` are 1 and `fault` is 0. `paddr` equals the matching entry's index in bits [17:12] and the request's offset in bits [11:0].
- R4: For a request taken at clock edge E, a hit at table index k sets `done` after edge E+k+1. That is, the result takes k+1 clock edges.
- R5: When several valid entries hold the same page, the one with the lowest index is returned.
- R6: When no valid entry matches, `done` and `fault` are 1 and `hit` is 0, after edge E+64 (one edge per entry, 64 entries by default).
- R7: An entry written with `wr_valid`=0 never matches, whatever page number it holds.
- R8: `done` is 1 for exactly one cycle per taken request.
- R9: A write (`wr_en`=1) is applied only when `req_ready` is 1. A write presented during a search leaves the table unchanged.
- R10: The page number is `req_vaddr[31:12]` and the offset is `req_vaddr[11:0]`. The offset reaches `paddr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Engine idle; a request or write is accepted |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | 6 | Frame index to write |
| wr_vpn | input | 20 | Virtual page number to store |
| wr_valid | input | 1 | Valid flag to store (0 removes the mapping) |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | Completed lookup found a mapping |
| fault | output | 1 | Completed lookup found no mapping |
| paddr | output | 18 | Physical address: frame index joined with the offset |

## Verification
Each result is due a known number of edges after the accepting edge. A hit at index k completes after k+1 edges, and a miss after 64 edges. A table write takes effect at the next edge. The bench drives inputs on falling edges. After the accepting edge, it counts rising edges and samples `done` on the falling edge after each one, so the edge count it records can be compared exactly with k+1 or 64. On the falling edge after completion, it checks that `done` has dropped. It checks that `req_ready` is low on the falling edge right after a request is accepted. It checks that a write dropped during a search had no effect by the outcome of a later lookup.

// File: rtl/fle_pkg.sv
package fle_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_e;
endpackage

// File: rtl/fle_table.sv
module fle_table #(
  parameter int VPN_W  = 20,
  parameter int FRAMES = 64,
  parameter int IDX_W  = $clog2(FRAMES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic              wr_valid,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [VPN_W-1:0]  rd_vpn,
  output logic              rd_valid,
  output logic [FRAMES-1:0] valid_vec
);

  logic [VPN_W-1:0] vpn_arr [FRAMES];

  for (genvar g = 0; g < FRAMES; g++) begin : g_ent
    logic             sel;
    logic             v_q;
    logic [VPN_W-1:0] p_q;

    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
      end else if (sel) begin
        v_q <= wr_valid;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        p_q <= wr_vpn;
      end
    end

    assign valid_vec[g] = v_q;
    assign vpn_arr[g]   = p_q;
  end

  assign rd_vpn   = vpn_arr[rd_idx];
  assign rd_valid = valid_vec[rd_idx];

  // A write lands in the addressed entry on the next edge.
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> (valid_vec[$past(wr_idx)] == $past(wr_valid))); // R9

endmodule

// File: rtl/fle_ctrl.sv
module fle_ctrl
  import fle_pkg::*;
#(
  parameter int VPN_W  = 20,
  parameter int OFF_W  = 12,
  parameter int FRAMES = 64,
  parameter int IDX_W  = $clog2(FRAMES),
  parameter int PA_W   = IDX_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic [OFF_W-1:0] req_off,
  output logic             req_ready,
  output logic [IDX_W-1:0] scan_idx,
  input  logic [VPN_W-1:0] ent_vpn,
  input  logic             ent_valid,
  output logic             done,
  output logic             hit,
  output logic             fault,
  output logic [PA_W-1:0]  paddr
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAMES - 1);

  scan_state_e      state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [VPN_W-1:0] vpn_q;
  logic [OFF_W-1:0] off_q;
  logic             done_q, done_d;
  logic             hit_q, hit_d;
  logic             fault_q, fault_d;
  logic [PA_W-1:0]  pa_q, pa_d;
  logic             load_en;
  logic             match;
  logic             at_last;

  assign req_ready = (state_q == ST_IDLE);
  assign load_en   = req_ready && req_valid;
  assign match     = ent_valid && (ent_vpn == vpn_q);
  assign at_last   = (idx_q == LAST_IDX);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    done_d  = 1'b0;
    hit_d   = hit_q;
    fault_d = fault_q;
    pa_d    = pa_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d = ST_SCAN;
          idx_d   = '0;
        end
      end
      ST_SCAN: begin
        if (match) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          hit_d   = 1'b1;
          fault_d = 1'b0;
          pa_d    = {idx_q, off_q};
        end else if (at_last) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          hit_d   = 1'b0;
          fault_d = 1'b1;
        end else begin
          idx_d   = idx_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
      hit_q   <= 1'b0;
      fault_q <= 1'b0;
      pa_q    <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
      hit_q   <= hit_d;
      fault_q <= fault_d;
      pa_q    <= pa_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      vpn_q <= req_vpn;
      off_q <= req_off;
    end
  end

  assign scan_idx = idx_q;
  assign done     = done_q;
  assign hit      = hit_q;
  assign fault    = fault_q;
  assign paddr    = pa_q;

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R8
  AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (hit_q != fault_q)); // R3
  AST_MISS_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && fault_q) |-> ($past(idx_q) == LAST_IDX)); // R6
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && hit_q) |-> (pa_q[OFF_W-1:0] == off_q)); // R10

endmodule

// File: rtl/frame_lookup_engine.sv
module frame_lookup_engine #(
  parameter int VA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int FRAMES = 64,
  parameter int VPN_W  = VA_W - OFF_W,
  parameter int IDX_W  = $clog2(FRAMES),
  parameter int PA_W   = IDX_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             req_ready,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic             wr_valid,
  output logic             done,
  output logic             hit,
  output logic             fault,
  output logic [PA_W-1:0]  paddr
);

  logic [IDX_W-1:0]  scan_idx;
  logic [VPN_W-1:0]  ent_vpn;
  logic              ent_valid;
  logic [FRAMES-1:0] valid_vec;
  logic              wr_gated;

  assign wr_gated = wr_en && req_ready;

  fle_table #(
    .VPN_W  (VPN_W),
    .FRAMES (FRAMES),
    .IDX_W  (IDX_W)
  ) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_gated),
    .wr_idx    (wr_idx),
    .wr_vpn    (wr_vpn),
    .wr_valid  (wr_valid),
    .rd_idx    (scan_idx),
    .rd_vpn    (ent_vpn),
    .rd_valid  (ent_valid),
    .valid_vec (valid_vec)
  );

  fle_ctrl #(
    .VPN_W  (VPN_W),
    .OFF_W  (OFF_W),
    .FRAMES (FRAMES),
    .IDX_W  (IDX_W),
    .PA_W   (PA_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_vpn   (req_vaddr[VA_W-1:OFF_W]),
    .req_off   (req_vaddr[OFF_W-1:0]),
    .req_ready (req_ready),
    .scan_idx  (scan_idx),
    .ent_vpn   (ent_vpn),
    .ent_valid (ent_valid),
    .done      (done),
    .hit       (hit),
    .fault     (fault),
    .paddr     (paddr)
  );

  AST_HIT_ENTRY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hit) |-> valid_vec[paddr[PA_W-1:OFF_W]]); // R7
  AST_TABLE_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !$past(req_ready)) |-> $stable(valid_vec)); // R9

endmodule

// File: tb/frame_lookup_engine_tb.sv
module frame_lookup_engine_tb;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic        req_ready;
  logic        wr_en;
  logic [5:0]  wr_idx;
  logic [19:0] wr_vpn;
  logic        wr_valid;
  logic        done;
  logic        hit;
  logic        fault;
  logic [17:0] paddr;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  frame_lookup_engine u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_vaddr (req_vaddr),
    .req_ready (req_ready),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_vpn    (wr_vpn),
    .wr_valid  (wr_valid),
    .done      (done),
    .hit       (hit),
    .fault     (fault),
    .paddr     (paddr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_entry(input logic [5:0] idx, input logic [19:0] vpn, input logic v);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_vpn = vpn; wr_valid = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Issue one lookup; return edges to completion and the outputs seen then.
  task automatic lookup(input logic [31:0] va, output int lat,
                        output logic h, output logic f, output logic [17:0] pa);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va;
    chk("R2 ready before request", {31'd0, req_ready}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 busy after accept", {31'd0, req_ready}, 32'd0);
    lat = 0;
    forever begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (done || lat > 80) break;
    end
    h = hit; f = fault; pa = paddr;
    @(negedge clk);
    chk("R8 done single cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic expect_hit(input string req, input logic [31:0] va, input int k);
    int lat; logic h, f; logic [17:0] pa;
    lookup(va, lat, h, f, pa);
    chk({req, " R3 hit"}, {30'd0, h, f}, 32'd2);
    chk({req, " R3/R10 paddr"}, {14'd0, pa}, {14'd0, 6'(k), va[11:0]});
    chk({req, " R4 latency"}, 32'(lat), 32'(k + 1));
  endtask

  task automatic expect_fault(input string req, input logic [31:0] va);
    int lat; logic h, f; logic [17:0] pa;
    lookup(va, lat, h, f, pa);
    chk({req, " R6 fault"}, {30'd0, h, f}, 32'd1);
    chk({req, " R6 latency"}, 32'(lat), 32'd64);
  endtask

  task automatic t_reset;
    chk("R1 ready", {31'd0, req_ready}, 32'd1);
    chk("R1 done/hit/fault", {29'd0, done, hit, fault}, 32'd0);
  endtask

  task automatic t_empty_table;
    expect_fault("R1 empty table", 32'h1234_5678);
  endtask

  task automatic t_hits;
    write_entry(6'd0,  20'hAAAAA, 1'b1);
    write_entry(6'd17, 20'h00BEE, 1'b1);
    write_entry(6'd63, 20'hFFFFF, 1'b1);
    expect_hit("R4 index0", 32'hAAAA_A123, 0);
    expect_hit("R10 index17", 32'h00BE_EFFF, 17);
    expect_hit("R10 index17 offset0", 32'h00BE_E000, 17);
    expect_hit("R4 index63", 32'hFFFF_F5A5, 63);
  endtask

  task automatic t_duplicate;
    write_entry(6'd30, 20'h0D0D0, 1'b1);
    write_entry(6'd9,  20'h0D0D0, 1'b1);
    expect_hit("R5 lowest index", 32'h0D0D_0777, 9);
  endtask

  task automatic t_invalid;
    write_entry(6'd50, 20'h55555, 1'b1);
    expect_hit("R7 before clear", 32'h5555_5001, 50);
    write_entry(6'd50, 20'h55555, 1'b0);
    expect_fault("R7 cleared entry", 32'h5555_5001);
  endtask

  task automatic t_busy_write;
    int lat;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 32'h7777_7042;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    wr_en = 1'b1; wr_idx = 6'd40; wr_vpn = 20'h77777; wr_valid = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    req_valid = 1'b1; req_vaddr = 32'hAAAA_A000;
    chk("R2 ready low while busy", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 3;
    while (!done && lat < 90) begin
      @(negedge clk);
      lat++;
    end
    chk("R9 busy write dropped", {30'd0, hit, fault}, 32'd1);
    @(negedge clk);
    chk("R2 busy request not taken", {31'd0, done}, 32'd0);
    chk("R2 idle after busy", {31'd0, req_ready}, 32'd1);
    expect_fault("R9 table unchanged", 32'h7777_7042);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0;
    wr_en = 1'b0; wr_idx = '0; wr_vpn = '0; wr_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_empty_table();
    t_hits();
    t_duplicate();
    t_invalid();
    t_busy_write();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule